// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the single-wire command line of an SD or MMC card. Software-facing logic writes a 9-bit command word together with a 32-bit argument. The engine then builds the 48-bit command frame, adds its CRC7 checksum and shifts the frame out, most significant bit first. If the command word asks for a reply, the engine listens on the line for a bounded number of bit periods. It captures either a 48-bit short reply or a 136-bit long reply into four 32-bit response words.

Each command ends in exactly one of two sticky status flags. `resp_end` means the command finished: the reply arrived, or no reply was requested. `cmd_timeout` means the card stayed silent too long. Card-clock pacing comes from the `bit_en` input: each bit period is one system clock with `bit_en` high. Writing an all-zero command word stops any activity at once.

Top module: `sd_cmd_path`

## Requirements
- R1: After reset, `busy`=0, `cmd_oe`=0, `cmd_out`=1, `resp_end`=0, `cmd_timeout`=0, and all four response words are zero.
- R2: A write whose command word has bit 8 (go) set is accepted while idle. The fields of the command word are:
  - bits [5:0]: opcode
  - bit 6: reply wanted
  - bit 7: long reply

  On the following bit periods `cmd_out` carries 48 bits, MSB first, with `cmd_oe` high exactly for those bits. In order, the frame is:
  - 0
  - 1
  - the opcode
  - the argument
  - CRC7
  - 1
- R3: The CRC7 covers the first 40 frame bits and uses generator x^7+x^3+1. For example, opcode 0 with argument 0 gives 0x4A, and the frame ends in byte 0x95.
- R4: With bit 6 clear, `resp_end` rises and `busy` falls in the cycle after the end bit is processed, without waiting for a reply.
- R5: With a reply wanted, a 0 sampled on `cmd_in` marks the reply start. If none of the 64 bit periods after the end bit samples a 0, `cmd_timeout` rises and `busy` falls. A start bit seen in the 64th period is still accepted.
- R6: A short reply is 48 bits. Its 32 bits after the start bit, the direction bit and the 6 index bits go to `resp_w0`, MSB first, and `resp_w1` to `resp_w3` keep their values. `resp_end` rises after the 48th bit.
- R7: A long reply is 136 bits. Its last 128 bits fill `resp_w0` (most significant) through `resp_w3`, and `resp_end` rises after the 136th bit. No CRC check is made on replies.
- R8: `resp_end` and `cmd_timeout` are never both high. Both clear when a command is accepted.
- R9: Writing an all-zero command word returns the engine to idle on the next cycle, with `cmd_oe`=0 and `cmd_out`=1, and clears both status flags.
- R10: A nonzero write while busy is ignored, and the running frame continues unchanged. A nonzero write with bit 8 clear does not start a command.
- R11: While `bit_en` is low, the engine holds its position: `cmd_out` is stable and no bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One card bit period when high |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 9 | Opcode [5:0], reply wanted [6], long reply [7], go [8] |
| cmd_arg | input | 32 | Command argument |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Command in progress |
| resp_end | output | 1 | Completion flag (sticky) |
| cmd_timeout | output | 1 | No-reply flag (sticky) |
| resp_w0 | output | 32 | Response word 0, most significant |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |

## Verification
Bit k of the frame appears in the cycle that follows the k-th edge after the accepting edge. The bench compares `cmd_out` and `cmd_oe` in every one of those 48 cycles, and keeps that alignment by stepping on falling edges. When the 48th edge is processed, completion appears in the next cycle if no reply is wanted. Otherwise the edge starts a wait in which the 64th edge raises the timeout, so the bench checks the flag both one cycle before and in the cycle it is due. Reply bits are driven one per falling edge. The words and `resp_end` are checked in the cycle after the edge that takes the last reply bit. When `bit_en` is low, the bench adds no cycles to its count.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int OPC_W     = 6;
  localparam int WORD_W    = 9;
  localparam int BIT_WANT  = 6;
  localparam int BIT_LONG  = 7;
  localparam int BIT_GO    = 8;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int HDR_W     = 2 + OPC_W + ARG_W;
  localparam int FRAME_W   = HDR_W + CRC_W + 1;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int RWORD_W   = 32;
  localparam int CAP_W     = 4 * RWORD_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } cmd_state_e;
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
  import sd_cmd_pkg::*;
#(
  parameter int DATA_W = HDR_W,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = data_i[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc_o = acc;
  end
endmodule

// File: rtl/sd_cmd_tx_shift.sv
module sd_cmd_tx_shift
  import sd_cmd_pkg::*;
#(
  parameter int W = FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load_i)       sreg_d = load_val_i;
    else if (shift_i) sreg_d = {sreg_q[W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '1;
    else        sreg_q <= sreg_d;
  end

  assign msb_o = sreg_q[W-1];
endmodule

// File: rtl/sd_cmd_rx_capture.sv
module sd_cmd_rx_capture
  import sd_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_i,
  input  logic               bit_i,
  input  logic               commit_short_i,
  input  logic               commit_long_i,
  output logic [RWORD_W-1:0] w0_o,
  output logic [RWORD_W-1:0] w1_o,
  output logic [RWORD_W-1:0] w2_o,
  output logic [RWORD_W-1:0] w3_o
);
  logic [CAP_W-1:0]   cap_q, cap_d;
  logic [RWORD_W-1:0] w_q [4];
  logic [RWORD_W-1:0] w_d [4];

  always_comb begin
    cap_d = shift_i ? {cap_q[CAP_W-2:0], bit_i} : cap_q;
    for (int i = 0; i < 4; i++) w_d[i] = w_q[i];
    if (commit_long_i) begin
      for (int i = 0; i < 4; i++) w_d[i] = cap_d[CAP_W-1-i*RWORD_W -: RWORD_W];
    end else if (commit_short_i) begin
      // skip CRC7 and end bit in the low byte
      w_d[0] = cap_d[RWORD_W+7:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      for (int i = 0; i < 4; i++) w_q[i] <= '0;
    end else begin
      cap_q <= cap_d;
      for (int i = 0; i < 4; i++) w_q[i] <= w_d[i];
    end
  end

  assign w0_o = w_q[0];
  assign w1_o = w_q[1];
  assign w2_o = w_q[2];
  assign w3_o = w_q[3];
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_BITS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               cmd_wr,
  input  logic [WORD_W-1:0]  cmd_word,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic               cmd_in,
  output logic               cmd_out,
  output logic               cmd_oe,
  output logic               busy,
  output logic               resp_end,
  output logic               cmd_timeout,
  output logic [RWORD_W-1:0] resp_w0,
  output logic [RWORD_W-1:0] resp_w1,
  output logic [RWORD_W-1:0] resp_w2,
  output logic [RWORD_W-1:0] resp_w3
);
  localparam int MAXC  = (LONG_LEN > TIMEOUT_BITS) ? LONG_LEN : TIMEOUT_BITS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SEND_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_BITS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 2);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 2);

  cmd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, tmo_q, tmo_d;
  logic             want_q, want_d, long_q, long_d;
  logic             load, shift_tx, shift_rx, commit_s, commit_l;
  logic             tx_msb;
  logic [CRC_W-1:0] crc;
  logic [HDR_W-1:0] hdr;

  assign hdr = {2'b01, cmd_word[OPC_W-1:0], cmd_arg};

  sd_cmd_crc7 u_crc (.data_i(hdr), .crc_o(crc));

  sd_cmd_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .load_val_i({hdr, crc, 1'b1}), .shift_i(shift_tx), .msb_o(tx_msb)
  );

  sd_cmd_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_rx), .bit_i(cmd_in),
    .commit_short_i(commit_s), .commit_long_i(commit_l),
    .w0_o(resp_w0), .w1_o(resp_w1), .w2_o(resp_w2), .w3_o(resp_w3)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    tmo_d    = tmo_q;
    want_d   = want_q;
    long_d   = long_q;
    load     = 1'b0;
    shift_tx = 1'b0;
    shift_rx = 1'b0;
    commit_s = 1'b0;
    commit_l = 1'b0;
    if (cmd_wr && cmd_word == '0) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
      tmo_d   = 1'b0;
    end else if (cmd_wr && state_q == ST_IDLE && cmd_word[BIT_GO]) begin
      load    = 1'b1;
      state_d = ST_SEND;
      cnt_d   = '0;
      done_d  = 1'b0;
      tmo_d   = 1'b0;
      want_d  = cmd_word[BIT_WANT];
      long_d  = cmd_word[BIT_LONG];
    end else if (bit_en) begin
      unique case (state_q)
        ST_SEND: begin
          shift_tx = 1'b1;
          if (cnt_q == SEND_LAST) begin
            cnt_d = '0;
            if (want_q) state_d = ST_WAIT;
            else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_WAIT: begin
          if (!cmd_in) begin
            state_d = ST_RECV;
            cnt_d   = '0;
          end else if (cnt_q == WAIT_LAST) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_RECV: begin
          shift_rx = 1'b1;
          if (cnt_q == (long_q ? LONG_LAST : SHORT_LAST)) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            commit_l = long_q;
            commit_s = !long_q;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      want_q  <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
      want_q  <= want_d;
      long_q  <= long_d;
    end
  end

  assign cmd_oe      = (state_q == ST_SEND);
  assign cmd_out     = (state_q == ST_SEND) ? tx_msb : 1'b1;
  assign busy        = (state_q != ST_IDLE);
  assign resp_end    = done_q;
  assign cmd_timeout = tmo_q;
endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk
  import sd_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              cmd_wr,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_out,
  input logic              cmd_oe,
  input logic              busy,
  input logic              resp_end,
  input logic              cmd_timeout
);
  a_r2_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_end && cmd_timeout));

  a_r8_flag_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_end || cmd_timeout) |-> !busy);

  a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word == '0) |=> (!busy && !cmd_oe && cmd_out && !resp_end && !cmd_timeout));

  a_r11_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && !bit_en && !cmd_wr) |=> ($stable(cmd_out) && cmd_oe));

  a_r4_done_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_end) |-> !busy);
endmodule

bind sd_cmd_path sd_cmd_path_chk u_chk (.*);

// File: tb/sd_cmd_path_bench.sv
module sd_cmd_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [8:0]  cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, resp_end, cmd_timeout;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sd_cmd_path u_sd_cmd_path (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c[3] = ~c[3];
      if (f) c[0] = ~c[0];
    end
    return c;
  endfunction

  function automatic logic [47:0] mkframe(input logic [5:0] op, input logic [31:0] arg);
    return {2'b01, op, arg, crc7({2'b01, op, arg}), 1'b1};
  endfunction

  // issue a command and check each of the 48 bit periods
  task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg, input bit want,
                         input bit lng, input logic [47:0] frm, input int freeze_at,
                         input int poke_at, input string tag);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = {1'b1, lng, want, op}; cmd_arg = arg;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(resp_end == 0 && cmd_timeout == 0, "R8 flags cleared on accept", {resp_end, cmd_timeout}, 0);
    for (int k = 0; k < 48; k++) begin
      if (k == freeze_at) begin
        bit_en = 1'b0;
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          chk(cmd_out == frm[47-k] && cmd_oe, "R11 line held", cmd_out, frm[47-k]);
        end
        bit_en = 1'b1;
      end
      chk(cmd_out == frm[47-k] && cmd_oe == 1'b1, tag, {k, cmd_oe, cmd_out}, {k, 1'b1, frm[47-k]});
      if (k == poke_at) begin
        cmd_wr = 1'b1; cmd_word = 9'h1C5; cmd_arg = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      cmd_wr = 1'b0;
    end
    chk(cmd_oe == 1'b0, "R2 oe drops after end bit", cmd_oe, 0);
    if (!want)
      chk(resp_end && !cmd_timeout && !busy, "R4 done without reply", {resp_end, cmd_timeout, busy}, 3'b100);
    else
      chk(!resp_end && busy, "R5 waiting for reply", {resp_end, busy}, 2'b01);
  endtask

  task automatic give_resp(input logic [135:0] v, input int n, input int gap);
    for (int j = 0; j < gap; j++) begin
      cmd_in = 1'b1; @(negedge clk);
    end
    for (int k = 0; k < n; k++) begin
      cmd_in = v[n-1-k]; @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  function automatic logic [135:0] short_resp(input logic [5:0] idx, input logic [31:0] st);
    logic [39:0] h = {2'b00, idx, st};
    return {88'd0, h, crc7(h), 1'b1};
  endfunction

  initial begin
    logic [31:0] w1s, w2s, w3s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_oe && cmd_out && !resp_end && !cmd_timeout, "R1 reset outputs",
        {busy, cmd_oe, cmd_out, resp_end, cmd_timeout}, 5'b00100);
    chk({resp_w0, resp_w1, resp_w2, resp_w3} == '0, "R1 reset words",
        {resp_w0, resp_w1, resp_w2, resp_w3}, 0);

    // R2 R3 R4: opcode 0, known CRC 0x4A
    run_cmd(6'd0, 32'h0, 0, 0, 48'h40_0000_0000_95, -1, -1, "R3 frame op0");

    // R9 abort while idle clears status
    @(negedge clk); cmd_wr = 1; cmd_word = 9'h000;
    @(negedge clk); cmd_wr = 0;
    chk(!resp_end && !cmd_timeout && !busy, "R9 zero write clears flags", {resp_end, cmd_timeout, busy}, 0);

    // R7 long reply
    run_cmd(6'd2, 32'h0, 1, 1, mkframe(6'd2, 32'h0), -1, -1, "R2 frame op2");
    give_resp({2'b00, 6'b111111, 32'hA1B2C3D4, 32'h11223344, 32'h55667788, 32'h99AABBCC}, 136, 0);
    chk(resp_end && !cmd_timeout && !busy, "R7 long done", {resp_end, cmd_timeout, busy}, 3'b100);
    chk({resp_w0, resp_w1, resp_w2, resp_w3} ==
        {32'hA1B2C3D4, 32'h11223344, 32'h55667788, 32'h99AABBCC}, "R7 long words",
        {resp_w0, resp_w1, resp_w2, resp_w3},
        {32'hA1B2C3D4, 32'h11223344, 32'h55667788, 32'h99AABBCC});
    w1s = resp_w1; w2s = resp_w2; w3s = resp_w3;

    // R6 short reply, known CRC 0x2A for opcode 17
    run_cmd(6'd17, 32'h0, 1, 0, 48'h51_0000_0000_55, -1, -1, "R3 frame op17");
    give_resp(short_resp(6'd17, 32'h0000_0900), 48, 3);
    chk(resp_end && !cmd_timeout && !busy, "R6 short done", {resp_end, cmd_timeout, busy}, 3'b100);
    chk(resp_w0 == 32'h0000_0900, "R6 short word0", resp_w0, 32'h0000_0900);
    chk(resp_w1 == w1s && resp_w2 == w2s && resp_w3 == w3s, "R6 other words kept",
        {resp_w1, resp_w2, resp_w3}, {w1s, w2s, w3s});

    // R5 start seen in the 64th period; opcode 8 CRC 0x43
    run_cmd(6'd8, 32'h1AA, 1, 0, 48'h48_0000_01AA_87, -1, -1, "R3 frame op8");
    give_resp(short_resp(6'd8, 32'hDEADBEEF), 48, 63);
    chk(resp_end && !cmd_timeout, "R5 late start accepted", {resp_end, cmd_timeout}, 2'b10);
    chk(resp_w0 == 32'hDEADBEEF, "R6 word0 after late start", resp_w0, 32'hDEADBEEF);

    // R5 R8 timeout
    run_cmd(6'd5, 32'h00FF_8000, 1, 0, mkframe(6'd5, 32'h00FF_8000), -1, -1, "R2 frame op5");
    repeat (63) @(negedge clk);
    chk(!cmd_timeout && busy, "R5 no timeout before 64", {cmd_timeout, busy}, 2'b01);
    @(negedge clk);
    chk(cmd_timeout && !resp_end && !busy, "R5 timeout at 64", {cmd_timeout, resp_end, busy}, 3'b100);
    chk(resp_w0 == 32'hDEADBEEF, "R5 words untouched on timeout", resp_w0, 32'hDEADBEEF);

    // R11 freeze, R10 ignored write while busy
    run_cmd(6'd55, 32'hFFFF_0000, 0, 0, mkframe(6'd55, 32'hFFFF_0000), 10, 20, "R10 frame kept");

    // R10 write without go bit
    @(negedge clk); cmd_wr = 1; cmd_word = 9'h0C5;
    @(negedge clk); cmd_wr = 0;
    chk(!busy && !cmd_oe && resp_end, "R10 no go bit ignored", {busy, cmd_oe, resp_end}, 3'b001);

    // R9 abort mid-frame
    @(negedge clk); cmd_wr = 1; cmd_word = 9'h140; cmd_arg = 32'h1234;
    @(negedge clk); cmd_wr = 0;
    repeat (10) @(negedge clk);
    chk(busy && cmd_oe, "R9 running before abort", {busy, cmd_oe}, 2'b11);
    cmd_wr = 1; cmd_word = 9'h000;
    @(negedge clk); cmd_wr = 0;
    chk(!busy && !cmd_oe && cmd_out && !resp_end && !cmd_timeout, "R9 abort to idle",
        {busy, cmd_oe, cmd_out, resp_end, cmd_timeout}, 5'b00100);
    repeat (70) @(negedge clk);
    chk(!busy && !cmd_timeout && !resp_end, "R9 stays idle", {busy, cmd_timeout, resp_end}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule